// File: doc/BRIEF.md
# Write-Through Cache Bridge with Width Adaptation

This block sits in the memory path between a narrow CPU-side port and a wide memory-side port. It holds a set-associative cache in which one cache line is exactly one memory word. The low bits of a CPU address pick which CPU-sized slice of that line is meant. The remaining bits form the memory line address, split into a set index and a tag.

A read that hits returns its slice straight from the cache. A read that misses issues one memory read for the whole line and waits for the returning strobe. The line is then written into the way the least-recently-used policy picks, and the requested slice is handed to the CPU in the same cycle the memory data arrives.

Writes always go through to memory. The CPU write data is replicated across the wide bus, and the CPU byte mask is shifted onto the byte lanes of the addressed slice. A write that hits also merges its enabled bytes into the stored line. A write that misses leaves the cache unchanged. Only one request is in flight at a time, so requests complete strictly in order.

Top module: `wtc_bridge`

## Requirements
- R1: A synchronous reset invalidates every line, so the first read of any address after reset misses and issues a memory read.
- R2: A read miss issues exactly one memory read with `memWrite`=0, `memMask`=0 and `memAddr` equal to the CPU address shifted right by log2(MEM_DATA_BITS/CPU_DATA_BITS).
- R3: On a read miss, `cpuValid` is high in the same cycle as `memValid`, and `cpuRdata` carries the addressed slice of `memRdata`.
- R4: A read hit raises `cpuValid` in the cycle right after the request is accepted and issues no memory request.
- R5: CPU address bits [log2(ratio)-1:0] hold a slice index k, and k selects bits [CPU_DATA_BITS*k +: CPU_DATA_BITS] of the line; with the defaults, address 4L+k is slice k of line L.
- R6: Every write issues one memory write to the line address. `memWdata` holds the CPU data in every slice. `memMask` equals the CPU byte mask shifted left by k*CPU_DATA_BITS/8, and every other lane is 0.
- R7: A write that misses does not allocate a line, so a later read of that line misses and returns the memory contents.
- R8: A write that hits merges its enabled bytes into the cached line when the memory write is accepted, so a later read hits and returns the merged data.
- R9: `cpuReady` is high when idle and low from the cycle after acceptance until the request completes.
- R10: When every way of a set is valid, a miss replaces the least recently used way. With two ways, the line touched less recently is evicted.
- R11: A write never raises `cpuValid`.
- R12: While `memReq` is high and `memReady` is low, the memory request and its address, direction and data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | CPU request valid |
| cpuWrite | input | 1 | CPU request is a write |
| cpuAddr | input | CPU_ADDR_BITS | CPU word address |
| cpuWdata | input | CPU_DATA_BITS | CPU write data |
| cpuMask | input | CPU_DATA_BITS/8 | CPU byte enables |
| cpuReady | output | 1 | Block accepts a request this cycle |
| cpuValid | output | 1 | Read data strobe |
| cpuRdata | output | CPU_DATA_BITS | Read data |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | MEM_ADDR_BITS | Memory line address |
| memWdata | output | MEM_DATA_BITS | Memory write data |
| memMask | output | MEM_DATA_BITS/8 | Memory byte enables |
| memReady | input | 1 | Memory accepts the request |
| memValid | input | 1 | Memory read data strobe |
| memRdata | input | MEM_DATA_BITS | Memory read data |

## Verification
A request is accepted on the clock edge where `cpuReq` and `cpuReady` are both high. A read hit strobes in the cycle after that edge. A miss raises `memReq` one cycle later, and it strobes in whichever cycle the memory model returns `memValid`. A write shows its memory request in the second cycle after acceptance and may stall there on `memReady`.

The bench drives inputs and samples results on the falling edge. It records the cycle count when it drives each request. The monitor checks hit latency as exactly one cycle and checks that a miss strobe coincides with `memValid`. Hit or miss and the write fields are judged from counts and fields the memory model captured, read after `cpuReady` has returned high.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MRD,
    ST_MWAIT,
    ST_MWR
  } wtcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the incoming CPU request
    logic fill;      // install returning memory line into victim way
    logic merge;     // merge write bytes into the hit line
    logic touch;     // mark the hit way most recently used
    logic selMem;    // return data from memory bus instead of cache
  } wtcCtrl_t;

endpackage

// File: rtl/wtc_repl.sv
module wtc_repl #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int POLICY = 0,  // 0: least recently used, 1: round robin
  localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SETW-1:0] setIdx,
  input  logic [WAYS-1:0] validVec,
  input  logic            touchEn,
  input  logic            fillEn,
  input  logic [WAYW-1:0] touchWay,
  output logic [WAYW-1:0] victim
);

  logic            anyFree;
  logic [WAYW-1:0] freeWay;

  always_comb begin
    anyFree = 1'b0;
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validVec[w]) begin
        anyFree = 1'b1;
        freeWay = WAYW'(w);
      end
    end
  end

  generate
    if (POLICY == 0) begin : g_lru
      logic [WAYW-1:0] age [SETS][WAYS];
      logic [WAYW-1:0] oldWay;
      logic [WAYW-1:0] refAge;

      always_comb begin
        oldWay = '0;
        for (int w = 0; w < WAYS; w++) begin
          if (age[setIdx][w] == WAYW'(WAYS - 1)) oldWay = WAYW'(w);
        end
      end

      assign refAge = age[setIdx][touchWay];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) age[s][w] <= WAYW'(w);
          end
        end else if (touchEn || fillEn) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAYW'(w) == touchWay) age[setIdx][w] <= '0;
            else if (age[setIdx][w] < refAge) age[setIdx][w] <= age[setIdx][w] + 1'b1;
          end
        end
      end

      assign victim = anyFree ? freeWay : oldWay;
    end else begin : g_rr
      logic [WAYW-1:0] ptr [SETS];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (fillEn && !anyFree) begin
          ptr[setIdx] <= (ptr[setIdx] == WAYW'(WAYS - 1)) ? '0 : ptr[setIdx] + 1'b1;
        end
      end

      assign victim = anyFree ? freeWay : ptr[setIdx];
    end
  endgenerate

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cpuReq,
  input  logic     memReady,
  input  logic     memValid,
  input  logic     hit,
  input  logic     isWrite,
  output logic     cpuReady,
  output logic     cpuValid,
  output logic     memReq,
  output logic     memWrite,
  output wtcCtrl_t ctl
);

  wtcState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    cpuReady = 1'b0;
    cpuValid = 1'b0;
    memReq   = 1'b0;
    memWrite = 1'b0;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        cpuReady    = 1'b1;
        ctl.capture = cpuReq;
        if (cpuReq) nxtState = ST_LOOK;
      end
      ST_LOOK: begin
        if (isWrite) begin
          nxtState = ST_MWR;
        end else if (hit) begin
          cpuValid  = 1'b1;
          ctl.touch = 1'b1;
          nxtState  = ST_IDLE;
        end else begin
          nxtState = ST_MRD;
        end
      end
      ST_MRD: begin
        memReq = 1'b1;
        if (memReady) nxtState = ST_MWAIT;
      end
      ST_MWAIT: begin
        ctl.selMem = 1'b1;
        if (memValid) begin
          ctl.fill = 1'b1;
          cpuValid = 1'b1;
          nxtState = ST_IDLE;
        end
      end
      ST_MWR: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          ctl.merge = hit;
          ctl.touch = hit;
          nxtState  = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int CPU_DATA_BITS = 32,
  parameter int MEM_DATA_BITS = 128,
  parameter int MEM_ADDR_BITS = 10,
  parameter int CACHE_LINES   = 8,
  parameter int WAYS          = 2,
  parameter int REPL_POLICY   = 0,
  localparam int RATIO     = MEM_DATA_BITS / CPU_DATA_BITS,
  localparam int SUBW      = $clog2(RATIO),
  localparam int CPU_ADDR_BITS = SUBW + MEM_ADDR_BITS,
  localparam int CPU_BYTES = CPU_DATA_BITS / 8,
  localparam int MEM_BYTES = MEM_DATA_BITS / 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  wtcCtrl_t                 ctl,
  input  logic [CPU_ADDR_BITS-1:0] cpuAddr,
  input  logic                     cpuWrite,
  input  logic [CPU_DATA_BITS-1:0] cpuWdata,
  input  logic [CPU_BYTES-1:0]     cpuMask,
  input  logic [MEM_DATA_BITS-1:0] memRdata,
  output logic                     hit,
  output logic                     isWrite,
  output logic [CPU_DATA_BITS-1:0] cpuRdata,
  output logic [MEM_ADDR_BITS-1:0] memAddr,
  output logic [MEM_DATA_BITS-1:0] memWdata,
  output logic [MEM_BYTES-1:0]     memMask
);

  localparam int SETS = CACHE_LINES / WAYS;
  localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAGW = MEM_ADDR_BITS - SETW;
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1;

  // captured request
  logic [CPU_ADDR_BITS-1:0] reqAddr;
  logic                     reqWrite;
  logic [CPU_DATA_BITS-1:0] reqWdata;
  logic [CPU_BYTES-1:0]     reqMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
      reqMask  <= '0;
    end else if (ctl.capture) begin
      reqAddr  <= cpuAddr;
      reqWrite <= cpuWrite;
      reqWdata <= cpuWdata;
      reqMask  <= cpuMask;
    end
  end

  logic [SUBW-1:0] sub;
  logic [SETW-1:0] setIdx;
  logic [TAGW-1:0] reqTag;

  assign sub     = reqAddr[SUBW-1:0];
  assign setIdx  = reqAddr[SUBW +: SETW];
  assign reqTag  = reqAddr[CPU_ADDR_BITS-1 -: TAGW];
  assign memAddr = reqAddr[CPU_ADDR_BITS-1:SUBW];
  assign isWrite = reqWrite;

  // storage
  logic [MEM_DATA_BITS-1:0] lineMem  [SETS][WAYS];
  logic [TAGW-1:0]          tagMem   [SETS][WAYS];
  logic [WAYS-1:0]          validMem [SETS];

  logic [WAYS-1:0] hitVec;
  logic [WAYW-1:0] hitWay;
  logic [WAYW-1:0] victim;
  logic [MEM_DATA_BITS-1:0] hitLine;

  always_comb begin
    hitVec = '0;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == reqTag);
      if (hitVec[w]) hitWay = WAYW'(w);
    end
  end

  assign hit     = |hitVec;
  assign hitLine = lineMem[setIdx][hitWay];

  // write-side lane placement
  logic [MEM_BYTES-1:0]     laneMask;
  logic [MEM_DATA_BITS-1:0] wideData;
  logic [MEM_DATA_BITS-1:0] mergedLine;

  assign laneMask = MEM_BYTES'(reqMask) << (sub * CPU_BYTES);
  assign wideData = {RATIO{reqWdata}};
  assign memWdata = wideData;
  assign memMask  = reqWrite ? laneMask : '0;

  always_comb begin
    for (int b = 0; b < MEM_BYTES; b++) begin
      mergedLine[8*b +: 8] = laneMask[b] ? wideData[8*b +: 8] : hitLine[8*b +: 8];
    end
  end

  // read-side slice selection
  logic [MEM_DATA_BITS-1:0] srcLine;
  assign srcLine  = ctl.selMem ? memRdata : hitLine;
  assign cpuRdata = srcLine[sub*CPU_DATA_BITS +: CPU_DATA_BITS];

  always_ff @(posedge clk) begin
    if (ctl.fill) begin
      lineMem[setIdx][victim] <= memRdata;
      tagMem[setIdx][victim]  <= reqTag;
    end else if (ctl.merge) begin
      lineMem[setIdx][hitWay] <= mergedLine;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctl.fill) begin
      validMem[setIdx][victim] <= 1'b1;
    end
  end

  wtc_repl #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .POLICY(REPL_POLICY)
  ) u_repl (
    .clk     (clk),
    .rst     (rst),
    .setIdx  (setIdx),
    .validVec(validMem[setIdx]),
    .touchEn (ctl.touch),
    .fillEn  (ctl.fill),
    .touchWay(ctl.fill ? victim : hitWay),
    .victim  (victim)
  );

endmodule

// File: rtl/wtc_bridge.sv
module wtc_bridge
  import wtc_pkg::*;
#(
  parameter int CPU_DATA_BITS = 32,
  parameter int MEM_DATA_BITS = 128,
  parameter int MEM_ADDR_BITS = 10,
  parameter int CACHE_LINES   = 8,
  parameter int WAYS          = 2,
  parameter int REPL_POLICY   = 0,
  localparam int CPU_ADDR_BITS = $clog2(MEM_DATA_BITS / CPU_DATA_BITS) + MEM_ADDR_BITS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpuReq,
  input  logic                       cpuWrite,
  input  logic [CPU_ADDR_BITS-1:0]   cpuAddr,
  input  logic [CPU_DATA_BITS-1:0]   cpuWdata,
  input  logic [CPU_DATA_BITS/8-1:0] cpuMask,
  output logic                       cpuReady,
  output logic                       cpuValid,
  output logic [CPU_DATA_BITS-1:0]   cpuRdata,
  output logic                       memReq,
  output logic                       memWrite,
  output logic [MEM_ADDR_BITS-1:0]   memAddr,
  output logic [MEM_DATA_BITS-1:0]   memWdata,
  output logic [MEM_DATA_BITS/8-1:0] memMask,
  input  logic                       memReady,
  input  logic                       memValid,
  input  logic [MEM_DATA_BITS-1:0]   memRdata
);

  wtcCtrl_t ctl;
  logic     hit;
  logic     isWrite;

  wtc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cpuReq  (cpuReq),
    .memReady(memReady),
    .memValid(memValid),
    .hit     (hit),
    .isWrite (isWrite),
    .cpuReady(cpuReady),
    .cpuValid(cpuValid),
    .memReq  (memReq),
    .memWrite(memWrite),
    .ctl     (ctl)
  );

  wtc_datapath #(
    .CPU_DATA_BITS(CPU_DATA_BITS),
    .MEM_DATA_BITS(MEM_DATA_BITS),
    .MEM_ADDR_BITS(MEM_ADDR_BITS),
    .CACHE_LINES  (CACHE_LINES),
    .WAYS         (WAYS),
    .REPL_POLICY  (REPL_POLICY)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .cpuAddr (cpuAddr),
    .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata),
    .cpuMask (cpuMask),
    .memRdata(memRdata),
    .hit     (hit),
    .isWrite (isWrite),
    .cpuRdata(cpuRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memMask (memMask)
  );

endmodule

// File: rtl/wtc_bridge_chk.sv
module wtc_bridge_chk #(
  parameter int CPU_DATA_BITS = 32,
  parameter int MEM_DATA_BITS = 128,
  parameter int MEM_ADDR_BITS = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cpuReq,
  input logic                       cpuWrite,
  input logic                       cpuReady,
  input logic                       cpuValid,
  input logic                       memReq,
  input logic                       memWrite,
  input logic [MEM_ADDR_BITS-1:0]   memAddr,
  input logic [MEM_DATA_BITS-1:0]   memWdata,
  input logic [MEM_DATA_BITS/8-1:0] memMask,
  input logic                       memReady
);

  localparam int CPU_BYTES = CPU_DATA_BITS / 8;

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    cpuReq && cpuReady |=> !cpuReady);

  a_r9_strobe_while_busy: assert property (@(posedge clk) disable iff (rst)
    cpuValid |-> !cpuReady);

  a_r11_write_no_strobe: assert property (@(posedge clk) disable iff (rst)
    cpuReq && cpuReady && cpuWrite |=> !cpuValid);

  a_r12_hold_mem_req: assert property (@(posedge clk) disable iff (rst)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));

  a_r2_read_no_mask: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWrite |-> memMask == '0);

  a_r6_mask_in_slice: assert property (@(posedge clk) disable iff (rst)
    memReq && memWrite |-> $countones(memMask) <= CPU_BYTES);

endmodule

bind wtc_bridge wtc_bridge_chk #(
  .CPU_DATA_BITS(CPU_DATA_BITS),
  .MEM_DATA_BITS(MEM_DATA_BITS),
  .MEM_ADDR_BITS(MEM_ADDR_BITS)
) u_chk (.*);

// File: tb/test_wtc_bridge.sv
`timescale 1ns/1ps
module test_wtc_bridge;

  localparam int CW = 32, MW = 128, MA = 10;
  localparam int SUBW = 2, AW = SUBW + MA, CB = CW/8, MB = MW/8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpuReq, cpuWrite;
  logic [AW-1:0] cpuAddr;
  logic [CW-1:0] cpuWdata;
  logic [CB-1:0] cpuMask;
  logic          cpuReady, cpuValid;
  logic [CW-1:0] cpuRdata;
  logic          memReq, memWrite;
  logic [MA-1:0] memAddr;
  logic [MW-1:0] memWdata;
  logic [MB-1:0] memMask;
  logic          memReady, memValid;
  logic [MW-1:0] memRdata;

  always #4 clk = ~clk;

  wtc_bridge i_wtc_bridge (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [MW-1:0] memStore [int];

  function automatic logic [MW-1:0] memGet(input int a);
    logic [MW-1:0] v;
    if (memStore.exists(a)) return memStore[a];
    for (int k = 0; k < MW/CW; k++) v[CW*k +: CW] = (32'(a) * 32'h0001_0003) ^ (32'hA5C3_0000 + 32'(k));
    return v;
  endfunction

  int            rdCount = 0, wrCount = 0, stallCnt = 0;
  logic [MA-1:0] lastRdAddr, lastWrAddr;
  logic [MW-1:0] lastWrData;
  logic [MB-1:0] lastWrMask;
  bit            pend = 0;
  int            pendLat = 0;
  logic [MA-1:0] pendAddr;

  initial begin
    memReady = 1'b0; memValid = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      stallCnt++;
      memReady = (stallCnt % 3) != 0;
      if (pend) begin
        if (pendLat == 0) begin
          memValid = 1'b1;
          memRdata = memGet(int'(pendAddr));
          pend = 0;
        end else pendLat--;
      end
      #1;
      if (!rst && memReq && memReady) begin
        if (memWrite) begin
          logic [MW-1:0] cur;
          cur = memGet(int'(memAddr));
          for (int b = 0; b < MB; b++) if (memMask[b]) cur[8*b +: 8] = memWdata[8*b +: 8];
          memStore[int'(memAddr)] = cur;
          wrCount++;
          lastWrAddr = memAddr; lastWrData = memWdata; lastWrMask = memMask;
        end else begin
          rdCount++;
          lastRdAddr = memAddr;
          pend = 1; pendLat = 2; pendAddr = memAddr;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [CW-1:0] data;
    bit            miss;
    int            t0;
    string         req;
  } exp_t;
  exp_t expQ[$];
  int strobes = 0;

  always @(negedge clk) begin
    #2;
    if (!rst && cpuValid) begin
      strobes++;
      if (expQ.size() == 0) begin
        chk(0, "R11", "strobe with no read pending", MW'(cpuRdata), '0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(cpuRdata == e.data, e.req, "read data", MW'(cpuRdata), MW'(e.data));
        if (e.miss) chk(memValid === 1'b1, "R3", "strobe with memory data", MW'(memValid), 1);
        else        chk(cyc - e.t0 == 1, "R4", "hit latency", MW'(cyc - e.t0), 1);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic waitIdle();
    while (!cpuReady) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [CW-1:0] d,
                       input logic [CB-1:0] m, output int t0);
    @(negedge clk);
    waitIdle();
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d; cpuMask = m;
    t0 = cyc;
    @(negedge clk);
    cpuReq = 1'b0; cpuWrite = 1'b0;
    #2 chk(cpuReady == 1'b0, "R9", "ready low after accept", MW'(cpuReady), 0);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit expMiss, input string req);
    exp_t e;
    int r0, t0;
    logic [MW-1:0] line;
    line   = memGet(int'(a >> SUBW));
    e.data = line[CW*int'(a[SUBW-1:0]) +: CW];
    e.miss = expMiss;
    e.req  = req;
    r0 = rdCount;
    expQ.push_back(e);
    @(negedge clk);
    waitIdle();
    expQ[expQ.size()-1].t0 = cyc;
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = a; cpuWdata = '0; cpuMask = '0;
    t0 = cyc;
    @(negedge clk);
    cpuReq = 1'b0;
    #2 chk(cpuReady == 1'b0, "R9", "ready low after accept", MW'(cpuReady), 0);
    waitIdle();
    #3;
    chk(rdCount - r0 == (expMiss ? 1 : 0), expMiss ? "R2" : "R4", "memory reads issued",
        MW'(rdCount - r0), MW'(expMiss ? 1 : 0));
    if (expMiss) chk(lastRdAddr == a[AW-1:SUBW], "R2", "miss line address", MW'(lastRdAddr), MW'(a[AW-1:SUBW]));
    chk(expQ.size() == 0, req, "read completed", MW'(expQ.size()), 0);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [CW-1:0] d, input logic [CB-1:0] m);
    int w0, s0, t0;
    logic [MB-1:0] expMask;
    w0 = wrCount; s0 = strobes;
    expMask = MB'(m) << (CB * int'(a[SUBW-1:0]));
    issue(1'b1, a, d, m, t0);
    waitIdle();
    #3;
    chk(wrCount - w0 == 1, "R6", "one memory write", MW'(wrCount - w0), 1);
    chk(lastWrAddr == a[AW-1:SUBW], "R6", "write line address", MW'(lastWrAddr), MW'(a[AW-1:SUBW]));
    chk(lastWrMask == expMask, "R6", "write lane mask", MW'(lastWrMask), MW'(expMask));
    chk(lastWrData == {(MW/CW){d}}, "R6", "write data replicated", lastWrData, {(MW/CW){d}});
    chk(strobes == s0, "R11", "no strobe for write", MW'(strobes - s0), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    rst = 1'b1; cpuReq = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0; cpuMask = '0;
    repeat (4) @(negedge clk);
    #2;
    chk(cpuReady == 1'b1, "R9", "ready in reset", MW'(cpuReady), 1);
    chk(memReq == 1'b0, "R1", "no memory request in reset", MW'(memReq), 0);
    chk(cpuValid == 1'b0, "R1", "no strobe in reset", MW'(cpuValid), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R5: cold miss on line 5 slice 2
    doRead(12'd22, 1'b1, "R1");
    // R4 R5: other slices of line 5 hit
    doRead(12'd20, 1'b0, "R5");
    doRead(12'd21, 1'b0, "R5");
    doRead(12'd23, 1'b0, "R5");
    // R6 R8: write hit into line 5 slice 1, bytes 0 and 2
    doWrite(12'd21, 32'hDEAD_BEEF, 4'b0101);
    doRead(12'd21, 1'b0, "R8");
    doRead(12'd22, 1'b0, "R8");
    // R6 R7: write miss on line 9 slice 3 does not allocate
    doWrite(12'd39, 32'h1234_5678, 4'b1111);
    doRead(12'd39, 1'b1, "R7");
    // R10: lines 2, 6, 10 share set 2
    doRead(12'd8,  1'b1, "R10");
    doRead(12'd26, 1'b1, "R10");
    doRead(12'd9,  1'b0, "R10");
    doRead(12'd43, 1'b1, "R10");  // evicts line 6
    doRead(12'd10, 1'b0, "R10");  // line 2 kept
    doRead(12'd24, 1'b1, "R10");  // evicts line 10
    doRead(12'd41, 1'b1, "R10");  // evicts line 2
    doRead(12'd25, 1'b0, "R10");  // line 6 kept
    doRead(12'd11, 1'b1, "R10");  // line 2 gone
    // R6: write to slice 0 with upper bytes only, then merged read
    doWrite(12'd24, 32'hCAFE_F00D, 4'b1100);
    doRead(12'd24, 1'b0, "R8");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule